// File: doc/BRIEF.md
# ADC Result Register Bus Bridge

This block sits between an 8-bit processor bus and the result and control registers of an analog-to-digital converter. The converter side stores finished 10-bit samples into one of four result registers through a simple write port. Each sample is kept left-justified in a 16-bit word. The processor side reads these words one byte at a time.

A read of the high byte returns that byte at once. In the same access it copies the low byte of the same register into one shared 8-bit holding latch. A later read of the low byte address returns whatever the latch holds and never the live register. Software that reads high then low therefore gets a pair taken at one instant, even if the converter overwrites the register in between. Software that reads only the low byte gets whatever the last high-byte read left in the latch, and the block deliberately keeps that behaviour.

One control byte holds a trigger-enable flag in its top bit. Its other seven bits are fixed at 1. While the flag is set, a falling edge on the external trigger input produces a one-cycle conversion-start pulse. A software start request produces a start pulse regardless of the flag.

Top module: `adc_result_bridge`

## Requirements
- R1: A bus read at byte address 2*n (n = 0..3) presents bits 15:8 of result register n on busRdata in the cycle after busRd is sampled.
- R2: That same high-byte read copies bits 7:0 of result register n into the shared holding latch.
- R3: A bus read at byte address 2*n+1 presents the holding latch contents, not the live low byte. Without a preceding high-byte read of that register it returns stale data from an earlier read.
- R4: A 10-bit sample d is stored left-justified. The high byte reads as d[9:2], and the low byte reads as {d[1:0], 6'b000000}.
- R5: A resWr strobe stores resData into the register selected by resChan at the clock edge. After reset, all result registers and the holding latch are zero.
- R6: A read at address 8 returns {trgEn, 7'b1111111}. A write at address 8 sets trgEn from busWdata bit 7 and ignores bits 6:0.
- R7: The control byte reads 0x7F after reset, and also after any cycle in which standby is high. Standby takes priority over a simultaneous write.
- R8: With trgEn = 1, a falling edge on extTrigN raises convStart for exactly one cycle, in the second cycle after the edge that first samples extTrigN low. A rising edge gives no pulse. With trgEn = 0, the external trigger gives no pulse.
- R9: swStart drives convStart high in the same cycle, whatever the value of trgEn.
- R10: A read of any address above 8 returns 0xFF, and a write to such an address has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| standby | input | 1 | Returns the control byte to its reset value |
| busAddr | input | 4 | Byte address of the bus access |
| busRd | input | 1 | Read strobe, one cycle per access |
| busWr | input | 1 | Write strobe, one cycle per access |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data, registered, valid the cycle after busRd |
| resWr | input | 1 | Converter result write strobe |
| resChan | input | 2 | Result register index |
| resData | input | 10 | Converter sample |
| extTrigN | input | 1 | External trigger, active on its falling edge, asynchronous |
| swStart | input | 1 | Software conversion start request |
| convStart | output | 1 | Conversion start pulse |

## Verification
The checker watches every cycle for several properties. The fixed ones in the control byte's reserved bits, the 0xFF response at unmapped addresses and the 0x7F value read right after standby are checked at all times. It also checks that every software request yields a start pulse, and that every start pulse without a software request was preceded by a low trigger sample two cycles earlier. The consistent-pair and stale-latch behaviour of the low byte depends on the order of accesses across several cycles. The same holds for the left-justified packing and the exact single-cycle width of the trigger pulse. Only the bench's scripted sequences can show these, comparing each read against a value predicted from the samples written.

// File: rtl/adc_bridge_pkg.sv
package adc_bridge_pkg;

  // Widest channel index the strobe struct can carry.
  localparam int MAX_CHAN_W = 4;

  // Per-access strobes from control to datapath; at most one read flag is set.
  typedef struct packed {
    logic                  rdUpper;
    logic                  rdLower;
    logic                  rdCtrl;
    logic                  rdNone;
    logic [MAX_CHAN_W-1:0] chan;
  } bridgeStrobe_t;

endpackage

// File: rtl/adc_bridge_ctrl.sv
module adc_bridge_ctrl
  import adc_bridge_pkg::*;
#(
  parameter int CHANNELS = 4,
  parameter int ADDR_W   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              standby,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRd,
  input  logic              busWr,
  input  logic [7:0]        busWdata,
  input  logic              extTrigN,
  input  logic              swStart,
  output bridgeStrobe_t     strobe,
  output logic [7:0]        ctrlByte,
  output logic              convStart
);

  localparam int CHAN_W    = $clog2(CHANNELS);
  localparam int CTRL_ADDR = 2 * CHANNELS;

  logic isResult;
  logic isCtrl;
  logic trgEn;
  logic [2:0] trigSync;

  assign isResult = (busAddr < ADDR_W'(CTRL_ADDR));
  assign isCtrl   = (busAddr == ADDR_W'(CTRL_ADDR));

  always_comb begin
    strobe.rdUpper = busRd && isResult && !busAddr[0];
    strobe.rdLower = busRd && isResult &&  busAddr[0];
    strobe.rdCtrl  = busRd && isCtrl;
    strobe.rdNone  = busRd && !isResult && !isCtrl;
    strobe.chan    = MAX_CHAN_W'(busAddr[CHAN_W:1]);
  end

  // Trigger enable: standby wins over a bus write.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      trgEn <= 1'b0;
    end else if (standby) begin
      trgEn <= 1'b0;
    end else if (busWr && isCtrl) begin
      trgEn <= busWdata[7];
    end
  end

  assign ctrlByte = {trgEn, 7'h7F};

  // Two-flop synchronizer plus one history flop for falling-edge detection.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      trigSync <= 3'b111;
    end else begin
      trigSync <= {trigSync[1:0], extTrigN};
    end
  end

  assign convStart = swStart || (trgEn && trigSync[2] && !trigSync[1]);

endmodule

// File: rtl/adc_bridge_dp.sv
module adc_bridge_dp
  import adc_bridge_pkg::*;
#(
  parameter int CHANNELS = 4,
  parameter int RES_BITS = 10
) (
  input  logic                clk,
  input  logic                rstN,
  input  bridgeStrobe_t       strobe,
  input  logic [7:0]          ctrlByte,
  input  logic                resWr,
  input  logic [$clog2(CHANNELS)-1:0] resChan,
  input  logic [RES_BITS-1:0] resData,
  output logic [7:0]          busRdata
);

  localparam int CHAN_W = $clog2(CHANNELS);
  localparam int PAD    = 16 - RES_BITS;

  logic [RES_BITS-1:0] resReg  [CHANNELS];
  logic [15:0]         resWide [CHANNELS];
  logic [15:0]         selWide;
  logic [7:0]          holdLatch;

  for (genvar g = 0; g < CHANNELS; g++) begin : g_res
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        resReg[g] <= '0;
      end else if (resWr && resChan == CHAN_W'(g)) begin
        resReg[g] <= resData;
      end
    end
    assign resWide[g] = {resReg[g], {PAD{1'b0}}};
  end

  assign selWide = resWide[strobe.chan[CHAN_W-1:0]];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdLatch <= 8'h00;
      busRdata  <= 8'h00;
    end else begin
      if (strobe.rdUpper) begin
        busRdata  <= selWide[15:8];
        holdLatch <= selWide[7:0];
      end else if (strobe.rdLower) begin
        busRdata  <= holdLatch;
      end else if (strobe.rdCtrl) begin
        busRdata  <= ctrlByte;
      end else if (strobe.rdNone) begin
        busRdata  <= 8'hFF;
      end
    end
  end

endmodule

// File: rtl/adc_result_bridge.sv
module adc_result_bridge
  import adc_bridge_pkg::*;
#(
  parameter int CHANNELS = 4,
  parameter int RES_BITS = 10,
  parameter int ADDR_W   = 4
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        standby,
  input  logic [ADDR_W-1:0]           busAddr,
  input  logic                        busRd,
  input  logic                        busWr,
  input  logic [7:0]                  busWdata,
  output logic [7:0]                  busRdata,
  input  logic                        resWr,
  input  logic [$clog2(CHANNELS)-1:0] resChan,
  input  logic [RES_BITS-1:0]         resData,
  input  logic                        extTrigN,
  input  logic                        swStart,
  output logic                        convStart
);

  bridgeStrobe_t strobe;
  logic [7:0]    ctrlByte;

  adc_bridge_ctrl #(.CHANNELS(CHANNELS), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .standby(standby),
    .busAddr(busAddr), .busRd(busRd), .busWr(busWr), .busWdata(busWdata),
    .extTrigN(extTrigN), .swStart(swStart),
    .strobe(strobe), .ctrlByte(ctrlByte), .convStart(convStart)
  );

  adc_bridge_dp #(.CHANNELS(CHANNELS), .RES_BITS(RES_BITS)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .ctrlByte(ctrlByte),
    .resWr(resWr), .resChan(resChan), .resData(resData),
    .busRdata(busRdata)
  );

endmodule

// File: rtl/adc_bridge_checker.sv
module adc_bridge_checker #(
  parameter int CHANNELS = 4,
  parameter int ADDR_W   = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              standby,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busRd,
  input logic [7:0]        busRdata,
  input logic              extTrigN,
  input logic              swStart,
  input logic              convStart
);

  localparam int CTRL_ADDR = 2 * CHANNELS;

  assert_sw_start_R9: assert property (@(posedge clk) disable iff (!rstN)
    swStart |-> convStart);

  assert_unmapped_ff_R10: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && busAddr > ADDR_W'(CTRL_ADDR)) |=> (busRdata == 8'hFF));

  assert_reserved_ones_R6: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && busAddr == ADDR_W'(CTRL_ADDR)) |=> (busRdata[6:0] == 7'h7F));

  assert_standby_clear_R7: assert property (@(posedge clk) disable iff (!rstN)
    standby ##1 (busRd && busAddr == ADDR_W'(CTRL_ADDR)) |=> (busRdata == 8'h7F));

  assert_trig_source_R8: assert property (@(posedge clk) disable iff (!rstN)
    (convStart && !swStart) |-> ($past(extTrigN, 2) == 1'b0));

endmodule

bind adc_result_bridge adc_bridge_checker #(.CHANNELS(CHANNELS), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .standby(standby), .busAddr(busAddr), .busRd(busRd),
  .busRdata(busRdata), .extTrigN(extTrigN), .swStart(swStart), .convStart(convStart)
);

// File: tb/adc_result_bridge_bench.sv
module adc_result_bridge_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       standby = 1'b0;
  logic [3:0] busAddr = '0;
  logic       busRd = 1'b0;
  logic       busWr = 1'b0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic       resWr = 1'b0;
  logic [1:0] resChan = '0;
  logic [9:0] resData = '0;
  logic       extTrigN = 1'b1;
  logic       swStart = 1'b0;
  logic       convStart;

  int total = 0;
  int bad = 0;
  logic pend = 1'b0;
  logic [7:0] expQ [$];
  string tagQ [$];

  always #2.5 clk = ~clk;

  adc_result_bridge u_adc_result_bridge (
    .clk(clk), .rstN(rstN), .standby(standby), .busAddr(busAddr), .busRd(busRd),
    .busWr(busWr), .busWdata(busWdata), .busRdata(busRdata), .resWr(resWr),
    .resChan(resChan), .resData(resData), .extTrigN(extTrigN), .swStart(swStart),
    .convStart(convStart)
  );

  function automatic logic [7:0] hiOf(input logic [9:0] d); return d[9:2]; endfunction
  function automatic logic [7:0] loOf(input logic [9:0] d); return {d[1:0], 6'b0}; endfunction

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Monitor: compares each read result against the scoreboard queue.
  always @(posedge clk) pend <= busRd && rstN;
  always @(negedge clk) begin
    if (pend) begin
      if (expQ.size() == 0) begin
        check(1'b0, "unexpected read", busRdata, 0);
      end else begin
        logic [7:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(busRdata == e, t, busRdata, e);
      end
    end
  end

  task automatic busRead(input logic [3:0] a, input logic [7:0] e, input string tag);
    @(negedge clk);
    busAddr = a; busRd = 1'b1;
    expQ.push_back(e); tagQ.push_back(tag);
    @(negedge clk);
    busRd = 1'b0;
  endtask

  task automatic busWrite(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic putResult(input logic [1:0] ch, input logic [9:0] d);
    @(negedge clk);
    resChan = ch; resData = d; resWr = 1'b1;
    @(negedge clk);
    resWr = 1'b0;
  endtask

  task automatic finishRun();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // Reset state (R5, R7)
    busRead(4'd4, 8'h00, "R5 reset high byte");
    busRead(4'd5, 8'h00, "R5 reset latch");
    busRead(4'd8, 8'h7F, "R7 reset control");

    // Packing and consistent pair (R1, R2, R4)
    putResult(2'd0, 10'h2A5);
    putResult(2'd3, 10'h3FF);
    busRead(4'd0, hiOf(10'h2A5), "R1 R4 ch0 high");
    putResult(2'd0, 10'h001);
    busRead(4'd1, loOf(10'h2A5), "R2 ch0 low from latch");
    busRead(4'd6, hiOf(10'h3FF), "R1 ch3 high");
    busRead(4'd7, loOf(10'h3FF), "R4 ch3 low");
    busRead(4'd0, hiOf(10'h001), "R5 ch0 rewritten high");
    busRead(4'd1, loOf(10'h001), "R4 ch0 low");

    // Stale low-byte read (R3)
    putResult(2'd1, 10'h0C2);
    busRead(4'd3, loOf(10'h001), "R3 stale latch ch1");
    busRead(4'd2, hiOf(10'h0C2), "R1 ch1 high");
    busRead(4'd3, loOf(10'h0C2), "R3 ch1 low after high");

    // Control byte (R6, R7)
    busWrite(4'd8, 8'h80);
    busRead(4'd8, 8'hFF, "R6 enable set");
    busWrite(4'd8, 8'h00);
    busRead(4'd8, 8'h7F, "R6 reserved writes ignored");
    busWrite(4'd8, 8'hFF);
    @(negedge clk); standby = 1'b1;
    @(negedge clk); standby = 1'b0;
    busRead(4'd8, 8'h7F, "R7 standby clears");
    @(negedge clk);
    busAddr = 4'd8; busWdata = 8'h80; busWr = 1'b1; standby = 1'b1;
    @(negedge clk); busWr = 1'b0; standby = 1'b0;
    busRead(4'd8, 8'h7F, "R7 standby beats write");

    // Unmapped (R10)
    busWrite(4'd9, 8'h80);
    busRead(4'd9, 8'hFF, "R10 addr 9");
    busRead(4'd15, 8'hFF, "R10 addr 15");
    busRead(4'd8, 8'h7F, "R10 unmapped write ignored");

    // External trigger, enabled (R8)
    busWrite(4'd8, 8'h80);
    @(negedge clk); extTrigN = 1'b0;
    @(negedge clk); check(convStart == 1'b0, "R8 no pulse yet", convStart, 0);
    @(negedge clk); check(convStart == 1'b1, "R8 pulse", convStart, 1);
    @(negedge clk); check(convStart == 1'b0, "R8 single cycle", convStart, 0);
    begin
      int n = 0;
      for (int i = 0; i < 4; i++) begin @(negedge clk); n += convStart; end
      check(n == 0, "R8 held low no repeat", n, 0);
      extTrigN = 1'b1;
      n = 0;
      for (int i = 0; i < 5; i++) begin @(negedge clk); n += convStart; end
      check(n == 0, "R8 rising edge no pulse", n, 0);
    end

    // External trigger, disabled (R8) and software start (R9)
    busWrite(4'd8, 8'h00);
    begin
      int n = 0;
      @(negedge clk); extTrigN = 1'b0;
      for (int i = 0; i < 5; i++) begin @(negedge clk); n += convStart; end
      check(n == 0, "R8 disabled no pulse", n, 0);
      extTrigN = 1'b1;
    end
    repeat (3) @(negedge clk);
    swStart = 1'b1;
    #1 check(convStart == 1'b1, "R9 software start disabled", convStart, 1);
    @(negedge clk); swStart = 1'b0;
    #1 check(convStart == 1'b0, "R9 software start released", convStart, 0);

    repeat (4) @(negedge clk);
    check(expQ.size() == 0, "scoreboard drained", expQ.size(), 0);
    finishRun();
  end

endmodule